// File: doc/BRIEF.md
# Double-Buffered Transmit Byte Path

This block sits between a host register port and a serial data engine in a card-interface controller. It holds two byte banks of equal size. The host fills one bank one byte at a time, and the other bank is read out to the engine through a valid/ready stream. The banks exchange roles in two cases: the fill bank becomes full, or software arms a partial hand-off so that a short final block is sent. An exchange happens only when the drain bank has been read out completely. The byte count of the bank travels with it, so a short block produces exactly as many bytes as were written.

Two single-bit control registers are writable through a small select-and-data port. The partial register arms the short-block hand-off. The mask register gates the write-request interrupt. The raw write request is high whenever the fill bank can take a byte and no hand-off is waiting. The interrupt is this request with the mask applied.

Top module: `pingpong_txbuf`

## Requirements
- R1: After reset both banks are empty, bank 0 takes host writes, `tx_valid` is 0, `part_flag` is 0, `irq_mask` is 1, `wr_ready` and `tx_req` are 1, and `tx_irq` is 0.
- R2: A host byte is stored when `wr_en` and `wr_ready` are both high at a clock edge. Stored bytes leave on `tx_data` in the order they were written.
- R3: When the fill bank holds DEPTH (default 32) bytes and the drain bank is empty, the banks exchange roles at the next edge. `tx_valid` rises in the cycle after that edge.
- R4: While the fill bank is full and the drain bank still has bytes, `wr_ready` is 0. Host writes presented then are not stored and never appear on `tx_data`.
- R5: A control write with `ctl_sel`=0 and data bit 0 = 1 arms a hand-off. Once the drain bank is empty, a fill bank holding N bytes (0 < N < DEPTH) moves to the drain side. Exactly N bytes come out, and then `tx_valid` falls.
- R6: While a hand-off is armed and not yet taken, `wr_ready` is 0 and host writes are not stored.
- R7: An armed hand-off with an empty fill bank is dropped after one cycle. No exchange takes place, `tx_valid` stays 0, and `wr_ready` returns to 1.
- R8: `part_flag` takes data bit 0 on every write with `ctl_sel`=0 and holds otherwise. Software clears it by writing 0, which does not cancel an armed hand-off. Data bits above bit 0 have no effect.
- R9: `tx_req` equals `wr_ready`. `tx_irq` is `tx_req` AND NOT `irq_mask`. `irq_mask` takes data bit 0 on writes with `ctl_sel`=1.
- R10: A byte is consumed on each edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is 0, `tx_valid` and `tx_data` hold.
- R11: Banks never exchange while the drain side still has bytes to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Host byte |
| wr_ready | output | 1 | Fill bank can accept a byte |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | 0 = partial register, 1 = mask register |
| ctl_wdata | input | RW | Control write data (bit 0 used) |
| part_flag | output | 1 | Partial register bit 0 |
| irq_mask | output | 1 | Mask register bit 0 |
| tx_valid | output | 1 | Drain byte available |
| tx_data | output | DW | Drain byte |
| tx_ready | input | 1 | Engine accepts the byte |
| tx_req | output | 1 | Raw transmit write request |
| tx_irq | output | 1 | Masked write-request interrupt |

## Verification
The bench goes after the exchange boundary. It fills a bank while the other bank is stalled, so a design that exchanges early would lose or duplicate bytes in the stream. It arms short hand-offs behind a busy drain bank and on an empty fill bank. A wrong design would accept writes into a block that is already closed, emit stale bytes past the short count, or exchange an empty bank and stay stuck. Long random stretches of ready, write and control activity are checked against a queue model every cycle. This exposes ordering slips, writes lost when the bank is full, and interrupts that ignore the mask or the armed state.

// File: rtl/pptx_pkg.sv
package pptx_pkg;

  typedef enum logic {
    CSR_PART = 1'b0,
    CSR_MASK = 1'b1
  } csr_sel_e;

  // Fill bank is at capacity
  function automatic logic bank_full(input int unsigned cnt, input int unsigned depth);
    return cnt == depth;
  endfunction

  // Exchange rule: drain must be empty, and either the fill bank is full or
  // an armed short hand-off has at least one byte to move
  function automatic logic swap_due(input logic drain_empty, input logic full,
                                    input logic armed, input logic fill_nz);
    return drain_empty && (full || (armed && fill_nz));
  endfunction

  // Host may write while there is room and no hand-off waits
  function automatic logic host_room(input logic full, input logic armed);
    return !full && !armed;
  endfunction

endpackage

// File: rtl/pptx_bank.sv
module pptx_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pptx_swap_ctl.sv
module pptx_swap_ctl
  import pptx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             part_arm,
  input  logic             tx_ready,
  output logic             fill_idx,
  output logic             wr_ready,
  output logic             wr_fire,
  output logic [PTR_W-1:0] waddr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             tx_valid,
  output logic             swap_go
);

  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] drain_len;
  logic [CNT_W-1:0] rd_cnt;
  logic             armed;

  logic drain_empty;
  logic fill_full;
  logic rd_fire;
  logic arm_drop;

  assign drain_empty = (rd_cnt == drain_len);
  assign fill_full   = bank_full(int'(fill_cnt), DEPTH);
  assign tx_valid    = !drain_empty;
  assign wr_ready    = host_room(fill_full, armed);
  assign wr_fire     = wr_en && wr_ready;
  assign rd_fire     = tx_valid && tx_ready;
  assign swap_go     = swap_due(drain_empty, fill_full, armed, fill_cnt != '0);
  assign arm_drop    = armed && (fill_cnt == '0);
  assign waddr       = fill_cnt[PTR_W-1:0];
  assign rd_ptr      = rd_cnt[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_idx  <= 1'b0;
      fill_cnt  <= '0;
      drain_len <= '0;
      rd_cnt    <= '0;
    end else if (swap_go) begin
      fill_idx  <= ~fill_idx;
      drain_len <= fill_cnt;
      rd_cnt    <= '0;
      fill_cnt  <= '0;
    end else begin
      if (wr_fire) fill_cnt <= fill_cnt + CNT_W'(1);
      if (rd_fire) rd_cnt   <= rd_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (part_arm)            armed <= 1'b1;
    else if (swap_go || arm_drop) armed <= 1'b0;
  end

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));  // R4
  AST_SWAP_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |-> !tx_valid);  // R11
  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |=> (fill_idx != $past(fill_idx)) && wr_ready == !armed);  // R3
  AST_SWAP_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |=> tx_valid);  // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !swap_go) |=> tx_valid && $stable(rd_ptr));  // R10
  AST_ARMED_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    part_arm |=> !wr_ready);  // R6

endmodule

// File: rtl/pptx_csr.sv
module pptx_csr
  import pptx_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr_en,
  input  logic          ctl_sel,
  input  logic [RW-1:0] ctl_wdata,
  input  logic          req_raw,
  output logic          part_flag,
  output logic          irq_mask,
  output logic          part_arm,
  output logic          tx_irq
);

  logic wr_part;
  logic wr_mask;
  logic unused_hi;

  assign wr_part   = ctl_wr_en && (csr_sel_e'(ctl_sel) == CSR_PART);
  assign wr_mask   = ctl_wr_en && (csr_sel_e'(ctl_sel) == CSR_MASK);
  assign part_arm  = wr_part && ctl_wdata[0];
  assign unused_hi = ^ctl_wdata[RW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_flag <= 1'b0;
      irq_mask  <= 1'b1;
    end else begin
      if (wr_part) part_flag <= ctl_wdata[0];
      if (wr_mask) irq_mask  <= ctl_wdata[0];
    end
  end

  assign tx_irq = req_raw && !irq_mask;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_part |=> $stable(part_flag));  // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(irq_mask));  // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && ctl_wdata[0]) |=> !tx_irq);  // R9

endmodule

// File: rtl/pingpong_txbuf.sv
module pingpong_txbuf
  import pptx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int RW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int NBANK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          ctl_wr_en,
  input  logic          ctl_sel,
  input  logic [RW-1:0] ctl_wdata,
  output logic          part_flag,
  output logic          irq_mask,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          tx_req,
  output logic          tx_irq
);

  logic             fill_idx;
  logic             wr_fire;
  logic             swap_go;
  logic             part_arm;
  logic [PTR_W-1:0] waddr;
  logic [PTR_W-1:0] rd_ptr;
  logic [DW-1:0]    bank_rd [NBANK];

  pptx_swap_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .part_arm (part_arm),
    .tx_ready (tx_ready),
    .fill_idx (fill_idx),
    .wr_ready (wr_ready),
    .wr_fire  (wr_fire),
    .waddr    (waddr),
    .rd_ptr   (rd_ptr),
    .tx_valid (tx_valid),
    .swap_go  (swap_go)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pptx_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (wr_fire && (fill_idx == 1'(b))),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (bank_rd[b])
    );
  end

  assign tx_data = bank_rd[~fill_idx];
  assign tx_req  = wr_ready;

  pptx_csr #(.RW(RW)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr_en (ctl_wr_en),
    .ctl_sel   (ctl_sel),
    .ctl_wdata (ctl_wdata),
    .req_raw   (wr_ready),
    .part_flag (part_flag),
    .irq_mask  (irq_mask),
    .part_arm  (part_arm),
    .tx_irq    (tx_irq)
  );

  AST_NO_WRITE_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |-> !wr_fire);  // R2

endmodule

// File: tb/pingpong_txbuf_tb.sv
`timescale 1ns/1ps
module pingpong_txbuf_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 32;
  localparam int RW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          ctl_wr_en = 1'b0;
  logic          ctl_sel = 1'b0;
  logic [RW-1:0] ctl_wdata = '0;
  logic          part_flag, irq_mask, tx_valid, tx_req, tx_irq;
  logic [DW-1:0] tx_data;
  logic          tx_ready = 1'b0;

  pingpong_txbuf #(.DW(DW), .DEPTH(DEPTH), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .ctl_wr_en(ctl_wr_en), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .part_flag(part_flag), .irq_mask(irq_mask), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_req(tx_req), .tx_irq(tx_irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  int wd_cnt = 0;

  // Reference model: two byte queues plus control bits
  logic [DW-1:0] m_fill[$];
  logic [DW-1:0] m_drain[$];
  bit m_arm, m_flag, m_mask;

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit room;
    room = (m_fill.size() < DEPTH) && !m_arm;
    chk("R3", "tx_valid", int'(tx_valid), int'(m_drain.size() > 0));
    if (m_drain.size() > 0) chk("R2", "tx_data", int'(tx_data), int'(m_drain[0]));
    chk("R6", "wr_ready", int'(wr_ready), int'(room));
    chk("R9", "tx_req", int'(tx_req), int'(room));
    chk("R9", "tx_irq", int'(tx_irq), int'(room && !m_mask));
    chk("R8", "part_flag", int'(part_flag), int'(m_flag));
    chk("R9", "irq_mask", int'(irq_mask), int'(m_mask));
  endtask

  task automatic tick();
    int fs, ds;
    bit acc, cons, swp, drop, arm;
    #1 compare();
    @(posedge clk);
    fs   = m_fill.size();
    ds   = m_drain.size();
    acc  = wr_en && fs < DEPTH && !m_arm;
    cons = tx_ready && ds > 0;
    swp  = (ds == 0) && (fs == DEPTH || (m_arm && fs > 0));
    drop = m_arm && fs == 0;
    arm  = ctl_wr_en && !ctl_sel && ctl_wdata[0];
    if (cons) void'(m_drain.pop_front());
    if (swp) begin m_drain = m_fill; m_fill.delete(); end
    if (acc) m_fill.push_back(wr_data);
    if (arm) m_arm = 1'b1;
    else if (swp || drop) m_arm = 1'b0;
    if (ctl_wr_en) begin
      if (!ctl_sel) m_flag = ctl_wdata[0];
      else m_mask = ctl_wdata[0];
    end
    @(negedge clk);
    wr_en = 1'b0;
    ctl_wr_en = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; tick();
  endtask

  task automatic csr(input logic sel, input logic [RW-1:0] d);
    ctl_wr_en = 1'b1; ctl_sel = sel; ctl_wdata = d; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_arm = 0; m_flag = 0; m_mask = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk("R1", "tx_valid", int'(tx_valid), 0);
    chk("R1", "part_flag", int'(part_flag), 0);
    chk("R1", "irq_mask", int'(irq_mask), 1);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    chk("R1", "tx_irq", int'(tx_irq), 0);
    @(negedge clk);

    // R2 R3 R10: full bank, free-flowing drain
    tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h10));
    idle(40);

    // R4: fill both banks with drain stalled, extra writes must be dropped
    tx_ready = 1'b0;
    for (int i = 0; i < 2 * DEPTH + 5; i++) push(8'(8'h80 + i));
    idle(3);
    tx_ready = 1'b1;
    idle(2);
    tx_ready = 1'b0;  // R10: hold while stalled
    idle(3);
    tx_ready = 1'b1;
    idle(75);

    // R5 R6: short hand-off behind a busy drain bank
    tx_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    for (int i = 0; i < 5; i++) push(8'(8'hC0 + i));
    csr(1'b0, 32'h1);
    push(8'hEE);  // R6: stalled while armed
    push(8'hEF);
    csr(1'b0, 32'h0);  // R8: clearing flag keeps the arm
    tx_ready = 1'b1;
    idle(50);
    csr(1'b0, 32'hFFFF_FFFE);  // R8: upper bits ignored
    idle(3);

    // R7: arm with an empty fill bank
    csr(1'b0, 32'h1);
    idle(5);
    csr(1'b0, 32'h0);

    // R9: unmask and watch the interrupt follow the request
    csr(1'b1, 32'h0);
    tx_ready = 1'b0;
    for (int i = 0; i < 2 * DEPTH + 2; i++) push(8'(i * 3));
    tx_ready = 1'b1;
    idle(70);
    csr(1'b1, 32'hFFFF_FFFF);
    idle(2);

    // Random mix of all inputs
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = lfsr[0] | lfsr[3];
      wr_en = lfsr[1] | lfsr[5];
      wr_data = lfsr[15:8];
      if (lfsr[7:2] == 6'h15) begin
        ctl_wr_en = 1'b1; ctl_sel = 1'b0; ctl_wdata = {31'h0, lfsr[9]};
      end else if (lfsr[7:2] == 6'h2A) begin
        ctl_wr_en = 1'b1; ctl_sel = 1'b1; ctl_wdata = {31'h0, lfsr[11]};
      end
      tick();
    end
    tx_ready = 1'b1;
    idle(80);
    finish_run();
  end

endmodule